// File: doc/BRIEF.md
# Variable-Latency Four-Stage In-Order Pipeline

This block is a small in-order execution pipeline. It has four stages: fetch/decode, operand fetch, execute and write-back. It runs a short program of three-register arithmetic instructions that is held in an internal instruction store. The program is loaded through a write port while the pipeline is idle. A pulse on `start` then launches it. The pipeline reads the first `n_instr` entries, starting at address 0, and retires them in program order into a nine-entry register file.

The execute stage takes a different number of cycles for each opcode, and there is only one execute unit. A hazard unit therefore holds operand fetch, and every stage behind it, while execute is still busy. Each result is forwarded to operand fetch in the last cycle of its execute, and the dependent instruction captures it in that same cycle. The dependent instruction starts execute in the following cycle.

A cycle counter runs while the program executes. Cycle 1 is the cycle in which the first instruction is fetched. The counter stops at the cycle in which the final write-back happens, and `done` pulses once. A registered read port gives access to the register file. A retire port shows each write-back as it happens.

Top module: `vlp_core`

## Requirements
- R1: After reset, `done` and `ret_valid` are 0 and `cycle_count` is 0. Register k of the register file holds 3*k+2.
- R2: An instruction word has the opcode in bits [13:12], the destination in [11:8], the first source in [7:4] and the second source in [3:0]. The opcodes are 0 ADD, 1 SUB, 2 MUL and 3 DIV. The result is the first source combined with the second (first minus second for SUB), wrapped to 16 bits.
- R3: Fetch, operand fetch and write-back take one cycle each. Execute takes 1 cycle for ADD and SUB, 3 cycles for MUL and 5 cycles for DIV. A lone ADD finishes in cycle 4, a lone MUL in cycle 6 and a lone DIV in cycle 8.
- R4: There is a single execute unit. An instruction with no dependency still waits in operand fetch until the older instruction is in its last execute cycle. MUL followed by an independent DIV finishes in cycle 11.
- R5: A result is forwarded to operand fetch in its last execute cycle. The dependent instruction starts execute in the next cycle. ADD followed by a dependent ADD finishes in cycle 5, with the correct value.
- R6: The program MUL R5,R0,R1; DIV R6,R2,R3; ADD R7,R5,R6; SUB R8,R7,R4 finishes in cycle 13.
- R7: Instructions retire in program order, one per write-back cycle. Each retirement shows its destination and its result on the retire port in its write-back cycle.
- R8: MUL keeps the low 16 bits of the product. DIV gives the truncated quotient, and division by zero gives all ones.
- R9: While running, `cycle_count` holds the current cycle number. `done` is high for exactly the one cycle after the final write-back. From then on `cycle_count` keeps the number of the final write-back cycle.
- R10: A `start` pulse while a program is running has no effect.
- R11: `rd_data` shows the register selected by `rd_addr`, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write enable for the instruction store (accepted only when idle) |
| prog_addr | input | 4 | Instruction store address |
| prog_data | input | 14 | Instruction word |
| n_instr | input | 5 | Number of instructions to run (1 to 16), sampled at start |
| start | input | 1 | Launches the program when idle |
| rd_addr | input | 4 | Register file read address |
| rd_data | output | 16 | Registered register file read data |
| ret_valid | output | 1 | A write-back happens this cycle |
| ret_dst | output | 4 | Destination of the write-back |
| ret_data | output | 16 | Value written back |
| done | output | 1 | One-cycle pulse after the final write-back |
| cycle_count | output | 16 | Current cycle number, then frozen at the last write-back cycle |

## Verification
The bench sweeps every ordered pair of opcodes, both with and without a data dependency. It also runs a chain of dependent multiplies that overflows, a division by a register that was zeroed one instruction earlier, and a generated sixteen-instruction program.

Every write-back cycle is compared against a stage-occupancy recurrence. A design that forwarded one cycle late would show up as one extra cycle per dependency. A design that allowed a second instruction into execute would retire early or out of order. A design that skipped the zero-divisor case would write the wrong value into the register file.

A `start` pulse is issued in the middle of each run. A pipeline that restarted on it would show a cycle count that jumps back to 1.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } vlp_op_e;
endpackage

// File: rtl/vlp_regfile.sv
module vlp_regfile #(
  parameter int W         = 16,
  parameter int NREG      = 9,
  parameter int RW        = 4,
  parameter int INIT_STEP = 3,
  parameter int INIT_BASE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [RW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [RW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [RW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);
  localparam logic [RW-1:0] LASTR = RW'(NREG - 1);

  logic [W-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= W'(i * INIT_STEP + INIT_BASE);
    end else if (we && waddr <= LASTR) begin
      rf[waddr] <= wdata;
    end
  end

  assign ra_data = (ra_addr <= LASTR) ? rf[ra_addr] : '0;
  assign rb_data = (rb_addr <= LASTR) ? rf[rb_addr] : '0;
  assign rc_data = (rc_addr <= LASTR) ? rf[rc_addr] : '0;

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr <= LASTR)); // R2
endmodule

// File: rtl/vlp_exec.sv
module vlp_exec
  import vlp_pkg::*;
#(
  parameter int W       = 16,
  parameter int RW      = 4,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          issue,
  input  vlp_op_e       op,
  input  logic [RW-1:0] dst,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          busy,
  output logic          last,
  output logic [RW-1:0] dst_q,
  output logic [W-1:0]  res_q
);
  localparam int LMAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ALU) ? LAT_DIV : LAT_ALU)
                                            : ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU);
  localparam int CNTW = $clog2(LMAX + 1);

  logic [CNTW-1:0] cnt, lat_m1;
  logic [W-1:0]    res_d;

  always_comb begin
    unique case (op)
      OP_ADD:  begin res_d = a + b; lat_m1 = CNTW'(LAT_ALU - 1); end
      OP_SUB:  begin res_d = a - b; lat_m1 = CNTW'(LAT_ALU - 1); end
      OP_MUL:  begin res_d = a * b; lat_m1 = CNTW'(LAT_MUL - 1); end
      default: begin
        res_d  = (b == '0) ? '1 : a / b;
        lat_m1 = CNTW'(LAT_DIV - 1);
      end
    endcase
  end

  assign last = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      busy  <= 1'b0;
      cnt   <= '0;
      dst_q <= '0;
      res_q <= '0;
    end else if (issue) begin
      busy  <= 1'b1;
      cnt   <= lat_m1;
      dst_q <= dst;
      res_q <= res_d;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNTW'(1);
    end
  end

  AST_ISSUE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst || clear)
    issue |-> (!busy || last)); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst || clear)
    (busy && !last) |=> (busy && $stable(dst_q) && $stable(res_q))); // R3
endmodule

// File: rtl/vlp_hazard.sv
module vlp_hazard #(
  parameter int W  = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          of_valid,
  input  logic [RW-1:0] src1,
  input  logic [RW-1:0] src2,
  input  logic          ex_busy,
  input  logic          ex_last,
  input  logic [RW-1:0] ex_dst,
  input  logic [W-1:0]  ex_res,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_dst,
  input  logic [W-1:0]  wb_data,
  input  logic [W-1:0]  rf_a,
  input  logic [W-1:0]  rf_b,
  output logic          of_adv,
  output logic [W-1:0]  opa,
  output logic [W-1:0]  opb
);
  logic unit_busy, raw_pending, stall;

  assign unit_busy   = ex_busy && !ex_last;
  assign raw_pending = ex_busy && !ex_last && (src1 == ex_dst || src2 == ex_dst);
  assign stall       = of_valid && (unit_busy || raw_pending);
  assign of_adv      = of_valid && !stall;

  always_comb begin
    if (ex_last && src1 == ex_dst)        opa = ex_res;
    else if (wb_valid && src1 == wb_dst)  opa = wb_data;
    else                                  opa = rf_a;
    if (ex_last && src2 == ex_dst)        opb = ex_res;
    else if (wb_valid && src2 == wb_dst)  opb = wb_data;
    else                                  opb = rf_b;
  end

  AST_ISSUE_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (of_adv && ex_busy) |-> ex_last); // R5
endmodule

// File: rtl/vlp_core.sv
module vlp_core
  import vlp_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 9,
  parameter int DEPTH   = 16,
  parameter int CW      = 16,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 5,
  localparam int RW     = $clog2(NREG),
  localparam int AW     = $clog2(DEPTH),
  localparam int NW     = AW + 1,
  localparam int IW     = 2 + 3 * RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [IW-1:0] prog_data,
  input  logic [NW-1:0] n_instr,
  input  logic          start,
  input  logic [RW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          ret_valid,
  output logic [RW-1:0] ret_dst,
  output logic [W-1:0]  ret_data,
  output logic          done,
  output logic [CW-1:0] cycle_count
);
  logic [IW-1:0] imem [DEPTH];

  logic          running, start_acc;
  logic [NW-1:0] pc, n_q, ret_cnt;
  logic          if_v, of_v, if_adv, of_adv, fetch_take;
  logic [IW-1:0] if_instr, of_instr;
  vlp_op_e       of_op;
  logic [RW-1:0] of_dst, of_s1, of_s2;
  logic [W-1:0]  rf_a, rf_b, rf_c, opa, opb;
  logic          ex_busy, ex_last;
  logic [RW-1:0] ex_dst;
  logic [W-1:0]  ex_res;

  assign start_acc  = start && !running;
  assign if_adv     = if_v && (!of_v || of_adv);
  assign fetch_take = running && (!if_v || if_adv) && (pc < n_q);

  assign of_op  = vlp_op_e'(of_instr[IW-1 -: 2]);
  assign of_dst = of_instr[3*RW-1 -: RW];
  assign of_s1  = of_instr[2*RW-1 -: RW];
  assign of_s2  = of_instr[RW-1:0];

  // instruction store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (prog_we && !running) imem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (start_acc)       if_instr <= imem[0];
    else if (fetch_take) if_instr <= imem[pc[AW-1:0]];
  end

  // fetch stage occupancy and program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      if_v <= 1'b0;
      pc   <= '0;
    end else if (start_acc) begin
      if_v <= 1'b1;
      pc   <= NW'(1);
    end else if (running && (!if_v || if_adv)) begin
      if_v <= (pc < n_q);
      if (pc < n_q) pc <= pc + NW'(1);
    end
  end

  // operand fetch stage
  always_ff @(posedge clk) begin
    if (rst || start_acc) begin
      of_v     <= 1'b0;
      of_instr <= '0;
    end else if (if_adv) begin
      of_v     <= 1'b1;
      of_instr <= if_instr;
    end else if (of_adv) begin
      of_v <= 1'b0;
    end
  end

  vlp_hazard #(.W(W), .RW(RW)) u_haz (
    .clk(clk), .rst(rst), .of_valid(of_v), .src1(of_s1), .src2(of_s2),
    .ex_busy(ex_busy), .ex_last(ex_last), .ex_dst(ex_dst), .ex_res(ex_res),
    .wb_valid(ret_valid), .wb_dst(ret_dst), .wb_data(ret_data),
    .rf_a(rf_a), .rf_b(rf_b), .of_adv(of_adv), .opa(opa), .opb(opb)
  );

  vlp_exec #(.W(W), .RW(RW), .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)) u_ex (
    .clk(clk), .rst(rst), .clear(start_acc), .issue(of_adv), .op(of_op),
    .dst(of_dst), .a(opa), .b(opb), .busy(ex_busy), .last(ex_last),
    .dst_q(ex_dst), .res_q(ex_res)
  );

  // write-back stage, also the retire port
  always_ff @(posedge clk) begin
    if (rst || start_acc) begin
      ret_valid <= 1'b0;
      ret_dst   <= '0;
      ret_data  <= '0;
    end else begin
      ret_valid <= ex_last;
      ret_dst   <= ex_dst;
      ret_data  <= ex_res;
    end
  end

  vlp_regfile #(.W(W), .NREG(NREG), .RW(RW)) u_rf (
    .clk(clk), .rst(rst), .we(ret_valid), .waddr(ret_dst), .wdata(ret_data),
    .ra_addr(of_s1), .ra_data(rf_a), .rb_addr(of_s2), .rb_data(rf_b),
    .rc_addr(rd_addr), .rc_data(rf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rf_c;
  end

  // run control and cycle counter
  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      cycle_count <= '0;
      done        <= 1'b0;
      ret_cnt     <= '0;
      n_q         <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        running     <= 1'b1;
        cycle_count <= CW'(1);
        ret_cnt     <= '0;
        n_q         <= n_instr;
      end else if (running) begin
        if (ret_valid) ret_cnt <= ret_cnt + NW'(1);
        if (ret_valid && ret_cnt == n_q - NW'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          cycle_count <= cycle_count + CW'(1);
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(cycle_count)); // R9
  AST_EX_TO_WB: assert property (@(posedge clk) disable iff (rst)
    ex_last |=> ret_valid); // R7
endmodule

// File: tb/sim_vlp_core.sv
module sim_vlp_core;
  localparam int W = 16, NREG = 9, DEPTH = 16, CW = 16;
  localparam int RW = 4, AW = 4, NW = 5, IW = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, prog_we = 1'b0, start = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [IW-1:0] prog_data = '0;
  logic [NW-1:0] n_instr = '0;
  logic [RW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data, ret_data;
  logic          ret_valid, done;
  logic [RW-1:0] ret_dst;
  logic [CW-1:0] cycle_count;

  vlp_core u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .n_instr(n_instr), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data),
    .done(done), .cycle_count(cycle_count)
  );

  int nchk = 0, nbad = 0;
  int pop[DEPTH], pd[DEPTH], ps1[DEPTH], ps2[DEPTH];
  int plen = 0;
  int mreg[NREG];
  int last_wb = 0;
  int lcg = 12345;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lat(int op);
    return (op == 2) ? 3 : (op == 3) ? 5 : 1;
  endfunction

  function automatic int alu(int op, int a, int b);
    longint p;
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: begin p = longint'(a) * longint'(b); return int'(p & 64'hFFFF); end
      default: return (b == 0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  task automatic add_ins(int op, int d, int a, int b);
    pop[plen] = op; pd[plen] = d; ps1[plen] = a; ps2[plen] = b;
    plen++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) mreg[i] = 3 * i + 2;
  endtask

  task automatic run(string tcnt, string tdata);
    int ofc[DEPTH], exs[DEPTH], wbc[DEPTH], ev[DEPTH];
    int k;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = AW'(i);
      prog_data = {2'(pop[i]), 4'(pd[i]), 4'(ps1[i]), 4'(ps2[i])};
    end
    @(negedge clk);
    prog_we = 1'b0;
    for (int i = 0; i < plen; i++) begin
      ev[i] = alu(pop[i], mreg[ps1[i]], mreg[ps2[i]]);
      mreg[pd[i]] = ev[i];
    end
    // stage-entry recurrence: operand fetch frees when the older one enters execute
    ofc[0] = 2; exs[0] = 3;
    for (int i = 1; i < plen; i++) begin
      ofc[i] = (ofc[i-1] + 1 > exs[i-1]) ? ofc[i-1] + 1 : exs[i-1];
      exs[i] = (ofc[i] + 1 > exs[i-1] + lat(pop[i-1])) ? ofc[i] + 1 : exs[i-1] + lat(pop[i-1]);
    end
    for (int i = 0; i < plen; i++) wbc[i] = exs[i] + lat(pop[i]);
    last_wb = wbc[plen-1];
    n_instr = NW'(plen);
    start = 1'b1;
    @(posedge clk);
    k = 0;
    for (int t = 1; t <= last_wb + 2; t++) begin
      @(negedge clk);
      start = (t == 2);
      if (t == 3) chk(cycle_count == 3, "R10", "count after mid-run start", cycle_count, 3);
      if (ret_valid) begin
        chk(k < plen && wbc[k] == t, "R7", "write-back cycle", t, (k < plen) ? wbc[k] : -1);
        if (k < plen) begin
          chk(int'(ret_dst) == pd[k], "R7", "retire destination", ret_dst, pd[k]);
          chk(int'(ret_data) == ev[k], tdata, "retire value", ret_data, ev[k]);
        end
        k++;
      end else begin
        chk(k >= plen || wbc[k] != t, "R7", "missing write-back", 0, 1);
      end
      chk(done == (t == last_wb + 1), "R9", "done pulse", done, t == last_wb + 1);
    end
    chk(k == plen, "R7", "retire total", k, plen);
    chk(int'(cycle_count) == last_wb, tcnt, "final cycle count", cycle_count, last_wb);
    rd_addr = RW'(pd[plen-1]);
    @(negedge clk);
    chk(int'(rd_data) == mreg[pd[plen-1]], "R11", "register read", rd_data, mreg[pd[plen-1]]);
    plen = 0;
  endtask

  initial begin
    #1500000;
    nbad++;
    $display("FAIL R9 watchdog expired: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    do_reset();
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(ret_valid == 1'b0, "R1", "ret_valid after reset", ret_valid, 0);
    chk(cycle_count == '0, "R1", "count after reset", cycle_count, 0);
    for (int i = 0; i < NREG; i++) begin
      rd_addr = RW'(i);
      @(negedge clk);
      chk(int'(rd_data) == 3 * i + 2, "R1", "initial register", rd_data, 3 * i + 2);
    end

    // R3 lone instructions
    for (int op = 0; op < 4; op++) begin
      add_ins(op, 7, 2, 1);
      run("R3", "R2");
      chk(last_wb == 3 + lat(op), "R3", "lone latency", last_wb, 3 + lat(op));
    end

    // R6 the four-instruction example
    do_reset();
    add_ins(2, 5, 0, 1); add_ins(3, 6, 2, 3); add_ins(0, 7, 5, 6); add_ins(1, 8, 7, 4);
    run("R6", "R2");
    chk(int'(cycle_count) == 13, "R6", "example total cycles", cycle_count, 13);

    // R4 independent MUL then DIV; R5 dependent ADD pair
    add_ins(2, 5, 0, 1); add_ins(3, 6, 2, 3);
    run("R4", "R8");
    chk(int'(cycle_count) == 11, "R4", "MUL then independent DIV", cycle_count, 11);
    add_ins(0, 7, 1, 2); add_ins(0, 8, 7, 7);
    run("R5", "R5");
    chk(int'(cycle_count) == 5, "R5", "dependent ADD pair", cycle_count, 5);

    // all opcode pairs, with and without dependency
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int dep = 0; dep < 2; dep++) begin
          do_reset();
          add_ins(a, 5, 0, 1);
          add_ins(b, 6, dep ? 5 : 2, 3);
          run(dep ? "R5" : "R4", "R2");
        end

    // R8 overflow chain and zero divisor
    do_reset();
    add_ins(2, 1, 1, 1); add_ins(2, 1, 1, 1); add_ins(2, 1, 1, 1); add_ins(2, 2, 1, 1);
    run("R5", "R8");
    add_ins(1, 4, 4, 4); add_ins(3, 7, 0, 4); add_ins(3, 8, 7, 3);
    run("R4", "R8");

    // generated sixteen-instruction program
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
      add_ins((lcg >> 8) & 3, (lcg >> 12) % NREG, (lcg >> 16) % NREG, (lcg >> 20) % NREG);
    end
    run("R7", "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule